// File: doc/BRIEF.md
# Page Mapping Table Programmer

This block holds a table of page translations in registers. A window of virtual address space is cut into 64 KB pages, and each page has one table entry. A requester hands the block one mapping request. The request carries a target memory code, a virtual start address, a physical start address, a page size in kilobytes, a page count and a fixed flag. The block checks the request. If the request is legal, the block writes the entries one per clock cycle and then pulses `done` with a numeric status code.

A combinational lookup port turns any virtual address into three outputs: a physical page number, the stored target code and a valid flag. An init command clears every entry in one cycle. Software or a boot sequencer uses the block to set up and tear down the window through which external flash or PSRAM is reached.

Top module: `page_map_prog`

## Requirements
- R1: After reset `busy` and `done` are low and every lookup reports `lu_valid`=0, `lu_target`=0 and `lu_ppage`=0.
- R2: When the low 16 bits of `req_vaddr` or of `req_paddr` are not zero, the request ends with status 1. Alignment is checked first, so status 1 wins over every other error.
- R3: For an aligned request whose `req_psize_kb` is not 64, the status is 3. This check comes ahead of the range check.
- R4: The status is 5 when the request is aligned and sized correctly but its addresses do not fit. This happens when `req_vaddr` lies below `VBASE`, or at or beyond `VBASE` + 64 pages × 64 KB. It also happens when the start page index plus `req_count` exceeds 64. A failing request writes no entry.
- R5: A legal request with count N>0 raises `busy` for N cycles and writes one entry per cycle. `done` pulses with status 0 on the cycle after the last write, which is N+1 cycles after acceptance. Requests and init presented while `busy` is high are ignored.
- R6: With `req_fixed`=0, entry k of the run gets physical page (`req_paddr[23:16]` + k) mod 256.
- R7: With `req_fixed`=1, every entry of the run gets physical page `req_paddr[23:16]`.
- R8: Target codes are 2'b00 invalid, 2'b01 flash, 2'b10 PSRAM and 2'b11 reserved. The lookup returns the stored code and ppage. `lu_valid` is 1 only for 2'b01 and 2'b10.
- R9: When the block is idle, `init` clears every entry to target 0 and ppage 0 in one cycle. A request presented in the same cycle as `init` is dropped and gives no `done`.
- R10: A legal request with count 0 pulses `done` with status 0 one cycle after acceptance and writes nothing.
- R11: A lookup address outside the window returns `lu_valid`=0, `lu_target`=0 and `lu_ppage`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Mapping request present |
| req_target | input | 2 | Target memory code |
| req_vaddr | input | 32 | Virtual start address |
| req_paddr | input | 32 | Physical start address |
| req_psize_kb | input | 16 | Page size in KB |
| req_count | input | 8 | Number of pages |
| req_fixed | input | 1 | 1: all pages alias one physical page |
| init | input | 1 | Invalidate all entries |
| busy | output | 1 | Run of writes in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | Result code: 0, 1, 3 or 5 |
| lu_vaddr | input | 32 | Lookup virtual address |
| lu_valid | output | 1 | Lookup hits a usable entry |
| lu_target | output | 2 | Stored target code |
| lu_ppage | output | PPAGE_W | Stored physical page |

## Verification
The bench goes after the priority among errors: requests are built with several faults at once. A design that checks in the wrong order returns 3 or 5 where 1 is expected. Runs ending exactly on the last page, and runs one page past it, are used to expose off-by-one range logic. Off-by-one range logic either rejects a legal run or writes past the table.

A full table scan after every request catches several faults. It finds partial writes on failing requests, and a ppage that steps when fixed mode should hold it. It also finds requests or init accepted mid-run, which would change entries the reference model still expects.

// File: rtl/pmt_pkg.sv
package pmt_pkg;

    localparam int ADDR_W     = 32;
    localparam int PAGE_SHIFT = 16;
    localparam int PAGE_KB    = 64;
    localparam int PSZ_W      = 16;
    localparam int CNT_W      = 8;
    localparam int PG_W       = ADDR_W - PAGE_SHIFT;

    typedef enum logic [1:0] {
        TGT_NONE  = 2'b00,
        TGT_FLASH = 2'b01,
        TGT_PSRAM = 2'b10,
        TGT_RSVD  = 2'b11
    } tgt_e;

    typedef enum logic [2:0] {
        ST_OK    = 3'd0,
        ST_ALIGN = 3'd1,
        ST_PSIZE = 3'd3,
        ST_RANGE = 3'd5
    } status_e;

    typedef struct packed {
        tgt_e              tgt;
        logic [ADDR_W-1:0] va;
        logic [ADDR_W-1:0] pa;
        logic [PSZ_W-1:0]  psize_kb;
        logic [CNT_W-1:0]  count;
        logic              fixed;
    } map_req_t;

    function automatic logic tgt_usable(tgt_e t);
        return (t == TGT_FLASH) || (t == TGT_PSRAM);
    endfunction

    function automatic logic [PG_W-1:0] page_of(logic [ADDR_W-1:0] va,
                                                 logic [ADDR_W-1:0] base);
        logic [ADDR_W-1:0] off;
        off = va - base;
        return off[ADDR_W-1:PAGE_SHIFT];
    endfunction

    function automatic logic in_window(logic [ADDR_W-1:0] va,
                                       logic [ADDR_W-1:0] base, int n);
        return (va >= base) && (page_of(va, base) < PG_W'(n));
    endfunction

endpackage

// File: rtl/pmt_check.sv
module pmt_check import pmt_pkg::*; #(
    parameter int                NUM_PAGES = 64,
    parameter logic [ADDR_W-1:0] VBASE     = 32'h3C00_0000,
    localparam int               IDX_W     = $clog2(NUM_PAGES)
) (
    input  map_req_t         req,
    output status_e          code,
    output logic [IDX_W-1:0] start_idx
);
    logic [PG_W-1:0] pg;
    logic [PG_W:0]   pg_end;
    logic            misaligned;
    logic            bad_size;
    logic            bad_range;

    always_comb begin
        pg         = page_of(req.va, VBASE);
        pg_end     = {1'b0, pg} + (PG_W+1)'(req.count);
        misaligned = (req.va[PAGE_SHIFT-1:0] != '0) || (req.pa[PAGE_SHIFT-1:0] != '0);
        bad_size   = (req.psize_kb != PSZ_W'(PAGE_KB));
        bad_range  = !in_window(req.va, VBASE, NUM_PAGES) ||
                     (pg_end > (PG_W+1)'(NUM_PAGES));
        start_idx  = pg[IDX_W-1:0];
        // R2 then R3 then R4: first fault found decides the code
        if (misaligned)     code = ST_ALIGN;
        else if (bad_size)  code = ST_PSIZE;
        else if (bad_range) code = ST_RANGE;
        else                code = ST_OK;
    end
endmodule

// File: rtl/pmt_seq.sv
module pmt_seq import pmt_pkg::*; #(
    parameter int  NUM_PAGES = 64,
    parameter int  PPAGE_W   = 8,
    localparam int IDX_W     = $clog2(NUM_PAGES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fire,
    input  status_e            code,
    input  logic [IDX_W-1:0]   start_idx,
    input  logic [PPAGE_W-1:0] start_pp,
    input  logic [CNT_W-1:0]   count,
    input  logic               fixed,
    input  tgt_e               tgt,
    output logic               busy,
    output logic               done,
    output status_e            status,
    output logic               wr_en,
    output logic [IDX_W-1:0]   wr_idx,
    output tgt_e               wr_tgt,
    output logic [PPAGE_W-1:0] wr_pp
);
    logic               busy_q;
    logic               done_q;
    status_e            status_q;
    logic [IDX_W-1:0]   idx_q;
    logic [PPAGE_W-1:0] pp_q;
    logic [CNT_W-1:0]   left_q;
    logic               fixed_q;
    tgt_e               tgt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            status_q <= ST_OK;
            idx_q    <= '0;
            pp_q     <= '0;
            left_q   <= '0;
            fixed_q  <= 1'b0;
            tgt_q    <= TGT_NONE;
        end else begin
            done_q <= 1'b0;
            if (busy_q) begin
                idx_q  <= idx_q + 1'b1;
                left_q <= left_q - 1'b1;
                if (!fixed_q) pp_q <= pp_q + 1'b1;
                if (left_q == CNT_W'(1)) begin
                    busy_q   <= 1'b0;
                    done_q   <= 1'b1;
                    status_q <= ST_OK;
                end
            end else if (fire) begin
                if (code != ST_OK) begin
                    done_q   <= 1'b1;
                    status_q <= code;
                end else if (count == '0) begin
                    done_q   <= 1'b1;
                    status_q <= ST_OK;
                end else begin
                    busy_q  <= 1'b1;
                    idx_q   <= start_idx;
                    pp_q    <= start_pp;
                    left_q  <= count;
                    fixed_q <= fixed;
                    tgt_q   <= tgt;
                end
            end
        end
    end

    assign busy   = busy_q;
    assign done   = done_q;
    assign status = status_q;
    assign wr_en  = busy_q;
    assign wr_idx = idx_q;
    assign wr_tgt = tgt_q;
    assign wr_pp  = pp_q;

    a_r7_fixed_holds_page: assert property (@(posedge clk) disable iff (rst)
        (busy_q && $past(busy_q) && fixed_q) |-> $stable(pp_q));
    a_r5_run_has_pages: assert property (@(posedge clk) disable iff (rst)
        busy_q |-> (left_q != '0));
    a_r5_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done_q |-> !busy_q);
endmodule

// File: rtl/pmt_table.sv
module pmt_table import pmt_pkg::*; #(
    parameter int  NUM_PAGES = 64,
    parameter int  PPAGE_W   = 8,
    localparam int IDX_W     = $clog2(NUM_PAGES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  tgt_e               wr_tgt,
    input  logic [PPAGE_W-1:0] wr_pp,
    input  logic               lu_in,
    input  logic [IDX_W-1:0]   lu_idx,
    output logic               lu_valid,
    output tgt_e               lu_tgt,
    output logic [PPAGE_W-1:0] lu_pp
);
    tgt_e                 ent_tgt [NUM_PAGES];
    logic [PPAGE_W-1:0]   ent_pp  [NUM_PAGES];
    logic [NUM_PAGES-1:0] valid_vec;

    for (genvar g = 0; g < NUM_PAGES; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                ent_tgt[g] <= TGT_NONE;
                ent_pp[g]  <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                ent_tgt[g] <= wr_tgt;
                ent_pp[g]  <= wr_pp;
            end
        end
        assign valid_vec[g] = tgt_usable(ent_tgt[g]);
    end

    always_comb begin
        lu_valid = lu_in && valid_vec[lu_idx];
        lu_tgt   = lu_in ? ent_tgt[lu_idx] : TGT_NONE;
        lu_pp    = lu_in ? ent_pp[lu_idx] : '0;
    end

    a_r9_clear_all: assert property (@(posedge clk) disable iff (rst)
        clr |=> (valid_vec == '0));
endmodule

// File: rtl/page_map_prog.sv
module page_map_prog import pmt_pkg::*; #(
    parameter int                NUM_PAGES = 64,
    parameter int                PPAGE_W   = 8,
    parameter logic [ADDR_W-1:0] VBASE     = 32'h3C00_0000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [1:0]         req_target,
    input  logic [ADDR_W-1:0]  req_vaddr,
    input  logic [ADDR_W-1:0]  req_paddr,
    input  logic [PSZ_W-1:0]   req_psize_kb,
    input  logic [CNT_W-1:0]   req_count,
    input  logic               req_fixed,
    input  logic               init,
    output logic               busy,
    output logic               done,
    output logic [2:0]         status,
    input  logic [ADDR_W-1:0]  lu_vaddr,
    output logic               lu_valid,
    output logic [1:0]         lu_target,
    output logic [PPAGE_W-1:0] lu_ppage
);
    localparam int IDX_W = $clog2(NUM_PAGES);

    map_req_t           req;
    status_e            code;
    status_e            st;
    tgt_e               lu_t;
    logic [IDX_W-1:0]   start_idx;
    logic               fire;
    logic               clr;
    logic               wr_en;
    logic [IDX_W-1:0]   wr_idx;
    tgt_e               wr_tgt;
    logic [PPAGE_W-1:0] wr_pp;
    logic [PG_W-1:0]    lu_pg;
    logic               lu_in;

    assign req = '{tgt: tgt_e'(req_target), va: req_vaddr, pa: req_paddr,
                   psize_kb: req_psize_kb, count: req_count, fixed: req_fixed};

    // init wins over a request; both ignored mid-run
    assign fire = req_valid && !busy && !init;
    assign clr  = init && !busy;

    pmt_check #(.NUM_PAGES(NUM_PAGES), .VBASE(VBASE)) u_check (
        .req(req), .code(code), .start_idx(start_idx));

    pmt_seq #(.NUM_PAGES(NUM_PAGES), .PPAGE_W(PPAGE_W)) u_seq (
        .clk(clk), .rst(rst), .fire(fire), .code(code), .start_idx(start_idx),
        .start_pp(req.pa[PAGE_SHIFT +: PPAGE_W]), .count(req.count),
        .fixed(req.fixed), .tgt(req.tgt), .busy(busy), .done(done),
        .status(st), .wr_en(wr_en), .wr_idx(wr_idx), .wr_tgt(wr_tgt),
        .wr_pp(wr_pp));

    assign lu_pg = page_of(lu_vaddr, VBASE);
    assign lu_in = in_window(lu_vaddr, VBASE, NUM_PAGES);

    pmt_table #(.NUM_PAGES(NUM_PAGES), .PPAGE_W(PPAGE_W)) u_table (
        .clk(clk), .rst(rst), .clr(clr), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_tgt(wr_tgt), .wr_pp(wr_pp), .lu_in(lu_in),
        .lu_idx(lu_pg[IDX_W-1:0]), .lu_valid(lu_valid), .lu_tgt(lu_t),
        .lu_pp(lu_ppage));

    assign status    = st;
    assign lu_target = lu_t;

    a_r4_no_write_on_error: assert property (@(posedge clk) disable iff (rst)
        (fire && (code != ST_OK)) |=> !wr_en);
    a_r9_init_drops_req: assert property (@(posedge clk) disable iff (rst)
        (init && req_valid && !busy) |=> (!busy && !done));
    a_r3_code_legal: assert property (@(posedge clk) disable iff (rst)
        done |-> (st == ST_OK || st == ST_ALIGN || st == ST_PSIZE || st == ST_RANGE));
    a_r11_outside_invalid: assert property (@(posedge clk) disable iff (rst)
        !lu_in |-> !lu_valid);
endmodule

// File: tb/tb_page_map_prog.sv
`timescale 1ns/1ps
module tb_page_map_prog;
    localparam int          NP    = 64;
    localparam logic [31:0] VBASE = 32'h3C00_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_target = '0;
    logic [31:0] req_vaddr = '0;
    logic [31:0] req_paddr = '0;
    logic [15:0] req_psize_kb = '0;
    logic [7:0]  req_count = '0;
    logic        req_fixed = 1'b0;
    logic        init = 1'b0;
    logic        busy, done;
    logic [2:0]  status;
    logic [31:0] lu_vaddr = '0;
    logic        lu_valid;
    logic [1:0]  lu_target;
    logic [7:0]  lu_ppage;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    logic [1:0] m_tgt [NP];
    logic [7:0] m_pp  [NP];

    always #2.5 clk = ~clk;

    page_map_prog dut (.*);

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_status(logic [31:0] va, logic [31:0] pa,
                                      logic [15:0] ps, int cnt);
        longint pg;
        if (va[15:0] != 0 || pa[15:0] != 0) return 1;
        if (ps != 16'd64) return 3;
        if (va < VBASE) return 5;
        pg = longint'(va - VBASE) >> 16;
        if (pg >= NP || pg + cnt > NP) return 5;
        return 0;
    endfunction

    task automatic scan(string req);
        for (int i = 0; i < NP; i++) begin
            lu_vaddr = VBASE + (i << 16) + ($urandom % 65536);
            #0.1;
            chk(lu_valid == (m_tgt[i] == 2'b01 || m_tgt[i] == 2'b10), req, "lu_valid", lu_valid, 0);
            chk(lu_target == m_tgt[i], req, "lu_target", lu_target, m_tgt[i]);
            chk(lu_ppage == m_pp[i], req, "lu_ppage", lu_ppage, m_pp[i]);
        end
    endtask

    task automatic issue(logic [1:0] t, logic [31:0] va, logic [31:0] pa,
                         logic [15:0] ps, int cnt, bit fx, string req);
        int cyc;
        int es;
        int base;
        es = exp_status(va, pa, ps, cnt);
        req_target = t; req_vaddr = va; req_paddr = pa;
        req_psize_kb = ps; req_count = 8'(cnt); req_fixed = fx; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        while (!done && cyc < 400) begin
            @(negedge clk);
            cyc++;
        end
        chk(status == 3'(es), req, "status", status, es);
        chk(cyc == ((es == 0 && cnt > 0) ? cnt + 1 : 1), req, "latency", cyc,
            (es == 0 && cnt > 0) ? cnt + 1 : 1);
        if (es == 0) begin
            base = int'((va - VBASE) >> 16);
            for (int k = 0; k < cnt; k++) begin
                m_tgt[base + k] = t;
                m_pp[base + k]  = fx ? pa[23:16] : 8'(pa[23:16] + k);
            end
        end
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NP; i++) begin m_tgt[i] = 0; m_pp[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(busy == 0, "R1", "busy", busy, 0);
        chk(done == 0, "R1", "done", done, 0);
        scan("R1");

        // R6 incrementing run, R5 timing, R8 flash
        issue(2'b01, VBASE, 32'h0012_0000, 64, 5, 0, "R6");
        scan("R6");
        // R7 fixed run, PSRAM
        issue(2'b10, VBASE + (10 << 16), 32'h00FE_0000, 64, 6, 1, "R7");
        scan("R7");
        // R6 physical page wraps modulo 256
        issue(2'b01, VBASE + (20 << 16), 32'h00FE_0000, 64, 4, 0, "R6");
        scan("R6");
        // R8 reserved code stored but not usable
        issue(2'b11, VBASE + (30 << 16), 32'h0040_0000, 64, 2, 0, "R8");
        scan("R8");
        // R2 alignment wins over size and range faults
        issue(2'b01, VBASE - 32'h0001_0000 + 32'h10, 32'h0, 16, 3, 0, "R2");
        issue(2'b01, VBASE, 32'h0003_8000, 128, 3, 0, "R2");
        // R3 size wins over range
        issue(2'b01, 32'h1000_0000, 32'h0, 32, 3, 0, "R3");
        // R4 range edges
        issue(2'b10, VBASE + (60 << 16), 32'h0050_0000, 64, 4, 0, "R4");
        issue(2'b01, VBASE + (61 << 16), 32'h0060_0000, 64, 4, 0, "R4");
        issue(2'b01, VBASE + (64 << 16), 32'h0060_0000, 64, 1, 0, "R4");
        issue(2'b01, VBASE - 32'h0001_0000, 32'h0060_0000, 64, 1, 0, "R4");
        scan("R4");
        // R10 count zero
        issue(2'b01, VBASE + (40 << 16), 32'h0070_0000, 64, 0, 0, "R10");
        scan("R10");
        // R11 lookups outside the window
        lu_vaddr = VBASE - 1; #0.1;
        chk(lu_valid == 0 && lu_target == 0 && lu_ppage == 0, "R11", "below", lu_valid, 0);
        lu_vaddr = VBASE + (64 << 16); #0.1;
        chk(lu_valid == 0 && lu_target == 0 && lu_ppage == 0, "R11", "above", lu_valid, 0);

        // R5 request and init presented mid-run are ignored
        req_target = 2'b01; req_vaddr = VBASE + (45 << 16); req_paddr = 32'h0001_0000;
        req_psize_kb = 64; req_count = 10; req_fixed = 0; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk(busy == 1, "R5", "busy mid-run", busy, 1);
        req_vaddr = VBASE + (2 << 16); req_count = 3; req_target = 2'b10;
        req_valid = 1'b1; init = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; init = 1'b0;
        while (!done) @(negedge clk);
        chk(status == 0, "R5", "status", status, 0);
        for (int k = 0; k < 10; k++) begin m_tgt[45 + k] = 2'b01; m_pp[45 + k] = 8'(1 + k); end
        @(negedge clk);
        chk(done == 0, "R5", "single done", done, 0);
        scan("R5");

        // random mix
        for (int n = 0; n < 60; n++) begin
            logic [31:0] va, pa;
            logic [15:0] ps;
            int cnt;
            va  = VBASE + (($urandom % 70) << 16);
            if ($urandom % 10 == 0) va = VBASE - 32'h0001_0000;
            pa  = ($urandom % 256) << 16;
            if ($urandom % 8 == 0) va = va + ($urandom % 65535) + 1;
            if ($urandom % 8 == 0) pa = pa + 32'h100;
            ps  = ($urandom % 8 == 0) ? 16'(($urandom % 4) * 32) : 16'd64;
            cnt = $urandom % 24;
            issue(2'($urandom), va, pa, ps, cnt, 1'($urandom), "R4");
        end
        scan("R6");

        // R9 init clears all, request with it dropped
        req_target = 2'b01; req_vaddr = VBASE; req_paddr = 0; req_psize_kb = 64;
        req_count = 2; req_valid = 1'b1; init = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; init = 1'b0;
        for (int k = 0; k < 4; k++) begin
            chk(done == 0 && busy == 0, "R9", "no run", done, 0);
            @(negedge clk);
        end
        for (int i = 0; i < NP; i++) begin m_tgt[i] = 0; m_pp[i] = 0; end
        scan("R9");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule